// File: doc/BRIEF.md
# Chip-Select Edge Access Front-End

This block sits between a pin-level memory port and the core of a 64K x 16 word array. Each access begins when the chip-select line goes from low to high, as seen by the system clock. The block takes the address, the write-enable level, the write data and the two write-lock inputs from the first clock sample at which chip select is high. It keeps these values only if chip select then stays high long enough to pass a short glitch filter. From the captured values it decides whether the access is a read, a write, or a write that a lock blocks. It then holds the access open for at least the minimum cycle time of that kind.

Toward the array core the block raises a request that carries the direction, the address and the write data. The request stays up until the core answers with a one-cycle ready. On the pin side the block produces a data word and a drive enable for the tri-state bus. The enable follows the live chip-select and output-enable levels together with the kind of the current cycle. The last read word stays on the bus while a new read is still in flight. A chip-select edge that comes while an access is still open is dropped and recorded in a sticky flag.

Top module: `eaf_front`

## Requirements
- R1: After reset the bus drive enable `dq_oe` is 0, `core_req` is 0 and `overrun` is 0.
- R2: A chip-select high run shorter than GLITCH_CYC (default 2) consecutive clock samples starts no access and leaves `overrun` at 0.
- R3: For a qualified edge, the address, write-enable and data come from the first clock sample at which chip select is high. Changes to these inputs after that sample do not alter the values on `core_addr`, `core_we` or `core_wdata`.
- R4: Write-enable 1 at the edge gives a write request (`core_we`=1). Write-enable 0 gives a read request (`core_we`=0). The read word returned with `core_ready` becomes the bus data.
- R5: The lock inputs are active low and are sampled with the address. `lock_lo_n`=0 blocks writes whose address bit 15 is 0. `lock_hi_n`=0 blocks writes whose address bit 15 is 1. A blocked write raises no core request and leaves the stored word unchanged. Reads are never blocked.
- R6: `dq_oe` is 1 only when the current cycle is a read, chip select and output enable are both 1, and read data is available. During write and blocked cycles it is 0, and it is 0 whenever chip select is 0.
- R7: Output enable is not captured. A change on `oe_in` changes `dq_oe` in the same cycle, without waiting for a clock edge.
- R8: If output enable is 1 at a read's launch and a previous read exists, the bus keeps driving the previous read word until the new word arrives. If output enable is 0 at launch, the bus stays undriven until the new word arrives.
- R9: An access stays open for at least RD_CYC clocks (read, default 22) or WR_CYC clocks (write or blocked write, default 28), counted from its launch edge, and also until the core request has completed. A qualified edge that comes earlier is ignored and sets the sticky `overrun` output. An edge exactly RD_CYC or WR_CYC clocks after launch is accepted.
- R10: `core_req`, together with its address, direction and data, stays constant from launch until the cycle in which `core_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_in | input | 1 | Chip select; its rising edge starts an access |
| we_in | input | 1 | Write enable, sampled at the edge (1 = write) |
| oe_in | input | 1 | Output enable, live (1 = allow bus drive) |
| addr_in | input | 16 | Word address; the top bit selects the half |
| wdata_in | input | 16 | Write data, sampled at the edge |
| lock_lo_n | input | 1 | Active-low write lock for the lower half |
| lock_hi_n | input | 1 | Active-low write lock for the upper half |
| dq_out | output | 16 | Data presented on the bus |
| dq_oe | output | 1 | Bus drive enable (0 = high impedance) |
| overrun | output | 1 | Sticky flag: an edge arrived during an open access |
| core_req | output | 1 | Request to the array core |
| core_we | output | 1 | Request direction (1 = write) |
| core_addr | output | 16 | Request address |
| core_wdata | output | 16 | Request write data |
| core_ready | input | 1 | Core completes the request (one-cycle pulse) |
| core_rdata | input | 16 | Read word, valid with core_ready |

## Verification
The hardest situation to reach is a new chip-select edge whose launch falls exactly one clock before, or exactly on, the end of the minimum cycle window. The stimulus lowers chip select right after a launch, waits a counted number of negative clock edges, and then raises chip select again. Because of the glitch filter, this places the qualifying sample at launch plus RD_CYC-1 or launch plus RD_CYC (and WR_CYC for writes). The held-data behaviour across back-to-back reads is the other hard case. The bench slows the core responder so that the old word and the new word can each be observed on the bus, with output enable held high and then low across the edge.

// File: rtl/eaf_pkg.sv
`timescale 1ns/1ps
package eaf_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_BLOCK = 2'd3
  } acc_kind_t;
endpackage

// File: rtl/eaf_edge_qual.sv
`timescale 1ns/1ps
module eaf_edge_qual #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int GLITCH_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_in,
  input  logic              we_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              lock_lo_n,
  input  logic              lock_hi_n,
  output logic              launch,
  output logic              snap_we,
  output logic [ADDR_W-1:0] snap_addr,
  output logic [DATA_W-1:0] snap_data,
  output logic              snap_lock_lo_n,
  output logic              snap_lock_hi_n
);
  localparam int CNT_W  = $clog2(GLITCH_CYC + 1);
  localparam int SNAP_W = ADDR_W + DATA_W + 3;

  logic [CNT_W-1:0]  run_q, run_d;
  logic [SNAP_W-1:0] live_vec, snap_vec;

  assign live_vec = {we_in, lock_lo_n, lock_hi_n, addr_in, wdata_in};

  // consecutive high-sample counter, saturating at the filter length
  always_comb begin
    if (!cs_in)
      run_d = '0;
    else if (run_q == CNT_W'(GLITCH_CYC))
      run_d = run_q;
    else
      run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign launch = cs_in && (run_q == CNT_W'(GLITCH_CYC - 1));

  generate
    if (GLITCH_CYC < 2) begin : g_live
      assign snap_vec = live_vec;
    end else begin : g_held
      logic [SNAP_W-1:0] held_q;
      logic              first_hi;
      assign first_hi = cs_in && (run_q == '0);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        held_q <= '0;
        else if (first_hi) held_q <= live_vec;
      end
      assign snap_vec = held_q;

      // R2: a launch needs chip select high on this and the previous sample
      a_r2_launch_run: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (cs_in && $past(cs_in)));
    end
  endgenerate

  assign {snap_we, snap_lock_lo_n, snap_lock_hi_n, snap_addr, snap_data} = snap_vec;
endmodule

// File: rtl/eaf_seq.sv
`timescale 1ns/1ps
module eaf_seq
  import eaf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int RD_CYC = 22,
  parameter int WR_CYC = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              snap_we,
  input  logic [ADDR_W-1:0] snap_addr,
  input  logic [DATA_W-1:0] snap_data,
  input  logic              snap_lock_lo_n,
  input  logic              snap_lock_hi_n,
  input  logic              core_ready,
  output logic              core_req,
  output logic              core_we,
  output logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_wdata,
  output acc_kind_t         kind,
  output logic              rd_start,
  output logic              rd_done,
  output logic              overrun
);
  localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  logic              busy_q, busy_d;
  logic              req_q, req_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  acc_kind_t         kind_q, kind_d;
  logic              ovr_q, ovr_d;
  logic              free, accept, reject, blocked;

  assign free    = !busy_q || ((tmr_q == '0) && !req_q);
  assign accept  = launch && free;
  assign reject  = launch && !free;
  assign blocked = snap_we &&
                   (snap_addr[ADDR_W-1] ? !snap_lock_hi_n : !snap_lock_lo_n);

  always_comb begin
    busy_d = busy_q;
    req_d  = req_q && !core_ready;
    tmr_d  = tmr_q;
    kind_d = kind_q;
    ovr_d  = ovr_q || reject;
    if (accept) begin
      busy_d = 1'b1;
      if (!snap_we) begin
        kind_d = ACC_READ;
        tmr_d  = TMR_W'(RD_CYC - 1);
      end else begin
        kind_d = blocked ? ACC_BLOCK : ACC_WRITE;
        tmr_d  = TMR_W'(WR_CYC - 1);
      end
      req_d = !blocked;
    end else if (busy_q) begin
      if (tmr_q != '0) tmr_d = tmr_q - 1'b1;
      if ((tmr_q == '0) && !req_q) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      tmr_q  <= '0;
      kind_q <= ACC_NONE;
      ovr_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      req_q  <= req_d;
      tmr_q  <= tmr_d;
      kind_q <= kind_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      we_q   <= snap_we;
      addr_q <= snap_addr;
      data_q <= snap_data;
    end
  end

  assign core_req   = req_q;
  assign core_we    = we_q;
  assign core_addr  = addr_q;
  assign core_wdata = data_q;
  assign kind       = kind_q;
  assign rd_start   = accept && !snap_we;
  assign rd_done    = req_q && core_ready && (kind_q == ACC_READ);
  assign overrun    = ovr_q;

  // R10: request and its fields hold until the core answers
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !core_ready) |=> (req_q && $stable(addr_q) && $stable(we_q) && $stable(data_q)));

  // R9: the overrun flag never clears once set
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);

  // R9: an edge inside the timed window is flagged
  a_r9_early_edge_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && busy_q && (tmr_q != '0)) |=> ovr_q);

  // R5: a blocked write never reaches the core
  a_r5_block_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == ACC_BLOCK) |-> !req_q);
endmodule

// File: rtl/eaf_bus.sv
`timescale 1ns/1ps
module eaf_bus
  import eaf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_in,
  input  logic              oe_in,
  input  acc_kind_t         kind,
  input  logic              rd_start,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] core_rdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic [DATA_W-1:0] hold_q;
  logic              have_q, fresh_q, keep_q;
  logic              have_d, fresh_d, keep_d;

  always_comb begin
    have_d  = have_q || rd_done;
    fresh_d = fresh_q;
    keep_d  = keep_q;
    if (rd_start) begin
      fresh_d = 1'b0;
      keep_d  = oe_in && have_q;
    end else begin
      if (rd_done) fresh_d = 1'b1;
      if (!oe_in)  keep_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      fresh_q <= 1'b0;
      keep_q  <= 1'b0;
    end else begin
      have_q  <= have_d;
      fresh_q <= fresh_d;
      keep_q  <= keep_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (rd_done) hold_q <= core_rdata;
  end

  assign dq_out = hold_q;
  assign dq_oe  = cs_in && oe_in && (kind == ACC_READ) && (fresh_q || keep_q);

  // R6: no drive during write or blocked cycles
  a_r6_no_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == ACC_WRITE) || (kind == ACC_BLOCK)) |-> !dq_oe);

  // R4: the word returned by the core is what the bus presents next
  a_r4_new_word: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (dq_out == $past(core_rdata)));
endmodule

// File: rtl/eaf_front.sv
`timescale 1ns/1ps
module eaf_front
  import eaf_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int GLITCH_CYC = 2,
  parameter int RD_CYC     = 22,
  parameter int WR_CYC     = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_in,
  input  logic              we_in,
  input  logic              oe_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              lock_lo_n,
  input  logic              lock_hi_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              overrun,
  output logic              core_req,
  output logic              core_we,
  output logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_wdata,
  input  logic              core_ready,
  input  logic [DATA_W-1:0] core_rdata
);
  logic              rst_s1_q, rst_s2_q;
  logic              launch, snap_we, snap_lo_n, snap_hi_n;
  logic [ADDR_W-1:0] snap_addr;
  logic [DATA_W-1:0] snap_data;
  logic              rd_start, rd_done;
  acc_kind_t         kind;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  eaf_edge_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC)) u_qual (
    .clk(clk), .rst_n(rst_s2_q), .cs_in(cs_in), .we_in(we_in),
    .addr_in(addr_in), .wdata_in(wdata_in),
    .lock_lo_n(lock_lo_n), .lock_hi_n(lock_hi_n),
    .launch(launch), .snap_we(snap_we), .snap_addr(snap_addr), .snap_data(snap_data),
    .snap_lock_lo_n(snap_lo_n), .snap_lock_hi_n(snap_hi_n)
  );

  eaf_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) u_seq (
    .clk(clk), .rst_n(rst_s2_q), .launch(launch), .snap_we(snap_we),
    .snap_addr(snap_addr), .snap_data(snap_data),
    .snap_lock_lo_n(snap_lo_n), .snap_lock_hi_n(snap_hi_n),
    .core_ready(core_ready), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .kind(kind),
    .rd_start(rd_start), .rd_done(rd_done), .overrun(overrun)
  );

  eaf_bus #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_s2_q), .cs_in(cs_in), .oe_in(oe_in), .kind(kind),
    .rd_start(rd_start), .rd_done(rd_done), .core_rdata(core_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // R1: nothing driven or requested while held in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_s2_q |-> (!core_req && !overrun));
endmodule

// File: tb/eaf_front_tb_top.sv
`timescale 1ns/1ps
module eaf_front_tb_top;
  localparam int RD = 22;
  localparam int WR = 28;

  logic        clk = 1'b0;
  logic        rst_n, cs_in, we_in, oe_in, lock_lo_n, lock_hi_n;
  logic [15:0] addr_in, wdata_in;
  logic [15:0] dq_out, core_addr, core_wdata, core_rdata;
  logic        dq_oe, overrun, core_req, core_we, core_ready;

  int n_chk = 0;
  int n_err = 0;
  int lat   = 3;
  int wcnt  = 0;
  bit done  = 1'b0;
  logic [15:0] cmem [int];
  logic [15:0] xmem [int];

  always #2.5 clk = ~clk;

  eaf_front dut_i (
    .clk(clk), .rst_n(rst_n), .cs_in(cs_in), .we_in(we_in), .oe_in(oe_in),
    .addr_in(addr_in), .wdata_in(wdata_in), .lock_lo_n(lock_lo_n), .lock_hi_n(lock_hi_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .overrun(overrun), .core_req(core_req),
    .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_ready(core_ready), .core_rdata(core_rdata)
  );

  // array core model: answers a request after lat negative edges
  initial begin
    core_ready = 1'b0;
    core_rdata = '0;
    forever begin
      @(negedge clk);
      if (core_ready) begin
        core_ready = 1'b0;
      end else if (core_req) begin
        if (wcnt >= lat) begin
          core_ready = 1'b1;
          wcnt = 0;
          if (core_we) cmem[int'(core_addr)] = core_wdata;
          else core_rdata = cmem.exists(int'(core_addr)) ? cmem[int'(core_addr)] : 16'h0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  function automatic logic [15:0] xval(input logic [15:0] a);
    return xmem.exists(int'(a)) ? xmem[int'(a)] : 16'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // raise chip select; return at the negedge right after the launch edge
  task automatic start_access(input logic we, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    we_in = we; addr_in = a; wdata_in = d; cs_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    we_in = ~we; addr_in = ~a; wdata_in = ~d;
  endtask

  task automatic t_reset();
    chk("R1 dq_oe", dq_oe, 0);
    chk("R1 core_req", core_req, 0);
    chk("R1 overrun", overrun, 0);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    we_in = 1'b1; addr_in = 16'h0033; cs_in = 1'b1;
    @(negedge clk);
    cs_in = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R2 glitch no req", core_req, 0);
    end
    chk("R2 glitch no overrun", overrun, 0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [15:0] d, input bit blk);
    oe_in = 1'b1;
    start_access(1'b1, a, d);
    if (blk) begin
      chk("R5 blocked no req", core_req, 0);
      lock_lo_n = 1'b1; lock_hi_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk("R5 blocked stays quiet", core_req, 0);
      end
    end else begin
      chk("R4 write req", core_req, 1);
      chk("R4 write dir", core_we, 1);
      chk("R3 captured addr", core_addr, a);
      chk("R3 captured data", core_wdata, d);
      xmem[int'(a)] = d;
    end
    chk("R6 write hiz", dq_oe, 0);
    cs_in = 1'b0;
    repeat (WR + 4) @(negedge clk);
  endtask

  task automatic t_read(input logic [15:0] a);
    oe_in = 1'b1;
    start_access(1'b0, a, 16'h0);
    chk("R4 read req", core_req, 1);
    chk("R4 read dir", core_we, 0);
    chk("R3 read addr", core_addr, a);
    repeat (8) @(negedge clk);
    chk("R6 read drive", dq_oe, 1);
    chk("R4 read word", dq_out, xval(a));
    oe_in = 1'b0; #1;
    chk("R7 oe low live", dq_oe, 0);
    oe_in = 1'b1; #1;
    chk("R7 oe high live", dq_oe, 1);
    cs_in = 1'b0; #1;
    chk("R6 cs low hiz", dq_oe, 0);
    repeat (RD + 4) @(negedge clk);
  endtask

  task automatic t_keep();
    logic [15:0] v1, v2;
    v1 = xval(16'h0010);
    v2 = xval(16'h8020);
    t_read(16'h0010);
    lat = 10;
    oe_in = 1'b1;
    start_access(1'b0, 16'h8020, 16'h0);
    chk("R8 old word drive", dq_oe, 1);
    chk("R8 old word value", dq_out, v1);
    repeat (5) @(negedge clk);
    chk("R8 old word held", dq_out, v1);
    repeat (10) @(negedge clk);
    chk("R8 new word value", dq_out, v2);
    cs_in = 1'b0;
    repeat (RD + 4) @(negedge clk);
    oe_in = 1'b0;
    start_access(1'b0, 16'h0010, 16'h0);
    oe_in = 1'b1; #1;
    chk("R8 oe low at edge hiz", dq_oe, 0);
    repeat (4) @(negedge clk);
    chk("R8 hiz until new word", dq_oe, 0);
    repeat (11) @(negedge clk);
    chk("R8 new word drive", dq_oe, 1);
    chk("R8 new word after hiz", dq_out, v1);
    cs_in = 1'b0;
    lat = 3;
    repeat (RD + 4) @(negedge clk);
  endtask

  task automatic t_window(input logic we, input int k, input bit acc);
    start_access(we, 16'h0050, 16'h0BAD);
    cs_in = 1'b0;
    repeat (k - 2) @(negedge clk);
    we_in = 1'b0; addr_in = 16'h0010; cs_in = 1'b1;
    @(negedge clk);
    chk("R9 no overrun before", overrun, 0);
    @(negedge clk);
    if (acc) begin
      chk("R9 edge at window end accepted", core_req, 1);
      chk("R9 no overrun at window end", overrun, 0);
    end else begin
      chk("R9 early edge ignored", core_req, 0);
      chk("R9 early edge flagged", overrun, 1);
    end
    cs_in = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    rst_n = 1'b0; cs_in = 1'b0; we_in = 1'b0; oe_in = 1'b0;
    addr_in = '0; wdata_in = '0; lock_lo_n = 1'b1; lock_hi_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_glitch();
    t_write(16'h0010, 16'hA5C3, 1'b0);
    t_write(16'h8020, 16'h3C5A, 1'b0);
    t_read(16'h0010);
    t_read(16'h8020);
    lock_lo_n = 1'b0;
    t_write(16'h0010, 16'hBEEF, 1'b1);
    lock_lo_n = 1'b0;
    t_write(16'h8020, 16'h1111, 1'b0);
    t_read(16'h0010);
    t_read(16'h8020);
    lock_lo_n = 1'b1; lock_hi_n = 1'b0;
    t_write(16'h8020, 16'h2222, 1'b1);
    lock_hi_n = 1'b0;
    t_write(16'h0010, 16'h3333, 1'b0);
    t_read(16'h8020);
    t_read(16'h0010);
    lock_hi_n = 1'b1;
    t_keep();
    t_window(1'b0, RD, 1'b1);
    t_window(1'b1, WR, 1'b1);
    t_window(1'b0, RD - 1, 1'b0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule